// File: doc/BRIEF.md
# Write-Protect Key Sequence Guard

This block sits beside the word-load path of a sector-programmed flash controller. It watches every word load (low address bits plus data) and picks out fixed multi-word key sequences: a three-word unlock-and-arm key, a six-word disarm key, and two three-word keys that enter or leave an identification mode. From these it keeps a persistent protection flag and decides whether the sector load that follows a key may reach the array.

Protection takes effect only when a write period ends. The controller reports that moment with a one-cycle pulse. An arm or disarm key permits the current write period at once. The flag itself flips at the end of that period, even if no data words were loaded. While protection is set, every write period needs a fresh arm key, or the controller gets no permit. Unkeyed loads still run the controller's timer, but nothing is written. In identification mode the read path returns a manufacturer code or a device code instead of array data, chosen by the read address LSB.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset the protection flag is 0, the identification flag is 0 and the write permit is 1.
- R2: The protection flag changes only in the cycle after a write-period-end pulse.
- R3: While protection is set, the write permit is 0 unless an arm key has completed since the last write-period end. Unkeyed data loads leave both the permit and the flag unchanged.
- R4: The arm key is AAAA@5555, 5555@2AAA, A0A0@5555 (data@address, hex). The permit is 1 in the cycle after its last word. The protection flag is 1 after the next write-period end, even with no data loaded, and the permit then falls back to 0.
- R5: The disarm key is AAAA@5555, 5555@2AAA, 8080@5555, AAAA@5555, 5555@2AAA, 2020@5555. The permit is 1 in the cycle after its last word, and the protection flag is 0 after the next write-period end.
- R6: The key AAAA@5555, 5555@2AAA, 9090@5555 sets the identification flag. While that flag is set, rd_data is 0x001F when rd_addr_lsb is 0 and 0x0025 when it is 1. Otherwise rd_data equals arr_rdata.
- R7: The key AAAA@5555, 5555@2AAA, F0F0@5555 clears the identification flag.
- R8: A word that breaks a key sends the matcher to idle and is then judged as a possible first key word. Example: AAAA@5555 followed by a stray word voids the key, while AAAA@5555 repeated twice still leads into a valid key.
- R9: If a key's last word and a write-period-end pulse fall in the same cycle, the end pulse first applies and clears the old pending action. The new key's permit and pending action then take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | One word load this cycle |
| ld_addr | input | 15 | Low address bits of the load |
| ld_data | input | 16 | Data word of the load |
| wp_end | input | 1 | Pulse: the current write period has ended |
| rd_addr_lsb | input | 1 | Read address bit 0 |
| arr_rdata | input | 16 | Read data from the array |
| rd_data | output | 16 | Read data after identification override |
| wr_permit | output | 1 | The current write period may program the array |
| prot_on | output | 1 | Protection flag |
| id_mode | output | 1 | Identification mode flag |

## Verification
Two functions can fall in the same cycle: the end of a write period and the completion of a new key. The bench provokes this by finishing a disarm key and then sending the last word of an arm key together with the end pulse. The bench judges the result from the ports. Protection must drop because the old disarm action applies. The permit must stay high, and the next end pulse must set protection again, which shows the new arm action was kept rather than wiped.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_K1, M_K2, M_D3, M_D4, M_D5
  } mstate_t;

  localparam logic [15:0] ADR_A     = 16'h5555;
  localparam logic [15:0] ADR_B     = 16'h2AAA;
  localparam logic [15:0] DAT_K1    = 16'hAAAA;
  localparam logic [15:0] DAT_K2    = 16'h5555;
  localparam logic [15:0] DAT_ARM   = 16'hA0A0;
  localparam logic [15:0] DAT_DIS_A = 16'h8080;
  localparam logic [15:0] DAT_DIS_B = 16'h2020;
  localparam logic [15:0] DAT_ID_IN = 16'h9090;
  localparam logic [15:0] DAT_ID_OUT = 16'hF0F0;
endpackage

// File: rtl/wpg_key_match.sv
module wpg_key_match
  import wpg_pkg::*;
#(
  parameter int KB = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [KB-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          hit_arm,
  output logic          hit_dis,
  output logic          hit_id_in,
  output logic          hit_id_out
);
  mstate_t st_q, st_d;
  logic at_a, at_b, w_first, w_second;

  assign at_a     = (ld_addr == ADR_A[KB-1:0]);
  assign at_b     = (ld_addr == ADR_B[KB-1:0]);
  assign w_first  = at_a && (ld_data == DW'(DAT_K1));
  assign w_second = at_b && (ld_data == DW'(DAT_K2));

  always_comb begin
    hit_arm    = 1'b0;
    hit_dis    = 1'b0;
    hit_id_in  = 1'b0;
    hit_id_out = 1'b0;
    // default: a breaking word restarts, judged as a first word
    st_d = w_first ? M_K1 : M_IDLE;
    if (ld_valid) begin
      case (st_q)
        M_K1: if (w_second) st_d = M_K2;
        M_K2: begin
          if (at_a && ld_data == DW'(DAT_ARM)) begin
            hit_arm = 1'b1;
            st_d    = M_IDLE;
          end else if (at_a && ld_data == DW'(DAT_DIS_A)) begin
            st_d = M_D3;
          end else if (at_a && ld_data == DW'(DAT_ID_IN)) begin
            hit_id_in = 1'b1;
            st_d      = M_IDLE;
          end else if (at_a && ld_data == DW'(DAT_ID_OUT)) begin
            hit_id_out = 1'b1;
            st_d       = M_IDLE;
          end
        end
        M_D3: if (w_first) st_d = M_D4;
        M_D4: if (w_second) st_d = M_D5;
        M_D5: begin
          if (at_a && ld_data == DW'(DAT_DIS_B)) begin
            hit_dis = 1'b1;
            st_d    = M_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= M_IDLE;
    else if (ld_valid) st_q <= st_d;
  end
endmodule

// File: rtl/wpg_prot_state.sv
module wpg_prot_state (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_end,
  input  logic hit_arm,
  input  logic hit_dis,
  input  logic hit_id_in,
  input  logic hit_id_out,
  output logic prot_on,
  output logic unlocked,
  output logic id_mode
);
  logic prot_q, prot_d, unl_q, unl_d, parm_q, parm_d, pdis_q, pdis_d;
  logic id_q, id_d, upd_en;

  assign upd_en = wp_end | hit_arm | hit_dis | hit_id_in | hit_id_out;

  always_comb begin
    prot_d = prot_q;
    unl_d  = unl_q;
    parm_d = parm_q;
    pdis_d = pdis_q;
    id_d   = id_q;
    if (wp_end) begin
      if (parm_q) prot_d = 1'b1;
      if (pdis_q) prot_d = 1'b0;
      unl_d  = 1'b0;
      parm_d = 1'b0;
      pdis_d = 1'b0;
    end
    if (hit_arm) begin
      unl_d  = 1'b1;
      parm_d = 1'b1;
      pdis_d = 1'b0;
    end
    if (hit_dis) begin
      unl_d  = 1'b1;
      pdis_d = 1'b1;
      parm_d = 1'b0;
    end
    if (hit_id_in)  id_d = 1'b1;
    if (hit_id_out) id_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      unl_q  <= 1'b0;
      parm_q <= 1'b0;
      pdis_q <= 1'b0;
      id_q   <= 1'b0;
    end else if (upd_en) begin
      prot_q <= prot_d;
      unl_q  <= unl_d;
      parm_q <= parm_d;
      pdis_q <= pdis_d;
      id_q   <= id_d;
    end
  end

  assign prot_on  = prot_q;
  assign unlocked = unl_q;
  assign id_mode  = id_q;
endmodule

// File: rtl/wpg_id_mux.sv
module wpg_id_mux #(
  parameter int DW = 16,
  parameter logic [DW-1:0] MFR_CODE = 16'h001F,
  parameter logic [DW-1:0] DEV_CODE = 16'h0025
) (
  input  logic          id_mode,
  input  logic          sel_dev,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data
);
  always_comb begin
    if (!id_mode)     rd_data = arr_rdata;
    else if (sel_dev) rd_data = DEV_CODE;
    else              rd_data = MFR_CODE;
  end
endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard #(
  parameter int KB = 15,
  parameter int DW = 16,
  parameter logic [DW-1:0] MFR_CODE = 16'h001F,
  parameter logic [DW-1:0] DEV_CODE = 16'h0025
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [KB-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          wp_end,
  input  logic          rd_addr_lsb,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          wr_permit,
  output logic          prot_on,
  output logic          id_mode
);
  logic hit_arm, hit_dis, hit_id_in, hit_id_out, unlocked;

  wpg_key_match #(.KB(KB), .DW(DW)) i_match (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .hit_arm(hit_arm), .hit_dis(hit_dis),
    .hit_id_in(hit_id_in), .hit_id_out(hit_id_out)
  );

  wpg_prot_state i_state (
    .clk(clk), .rst_n(rst_n), .wp_end(wp_end), .hit_arm(hit_arm),
    .hit_dis(hit_dis), .hit_id_in(hit_id_in), .hit_id_out(hit_id_out),
    .prot_on(prot_on), .unlocked(unlocked), .id_mode(id_mode)
  );

  wpg_id_mux #(.DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_mux (
    .id_mode(id_mode), .sel_dev(rd_addr_lsb), .arr_rdata(arr_rdata),
    .rd_data(rd_data)
  );

  assign wr_permit = !prot_on || unlocked;
endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wp_end,
  input logic hit_arm,
  input logic hit_dis,
  input logic hit_id_in,
  input logic hit_id_out,
  input logic wr_permit,
  input logic prot_on,
  input logic id_mode
);
  a_r2_prot_moves_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> $past(wp_end));
  a_r3_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !wr_permit && !hit_arm && !hit_dis) |=> !wr_permit);
  a_r4_arm_permits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_arm |=> wr_permit);
  a_r5_disarm_permits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dis |=> wr_permit);
  a_r6_id_enter: assert property (@(posedge clk) disable iff (!rst_n)
    hit_id_in |=> id_mode);
  a_r7_id_exit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_id_out |=> !id_mode);
  a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_arm, hit_dis, hit_id_in, hit_id_out}));
endmodule

bind wp_cmd_guard wp_cmd_guard_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wp_end(wp_end), .hit_arm(hit_arm),
  .hit_dis(hit_dis), .hit_id_in(hit_id_in), .hit_id_out(hit_id_out),
  .wr_permit(wr_permit), .prot_on(prot_on), .id_mode(id_mode)
);

// File: tb/test_wp_cmd_guard.sv
module test_wp_cmd_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [14:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        wp_end = 1'b0;
  logic        rd_addr_lsb = 1'b0;
  logic [15:0] arr_rdata = 16'h1234;
  logic [15:0] rd_data;
  logic        wr_permit, prot_on, id_mode;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wp_cmd_guard i_wp_cmd_guard (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .wp_end(wp_end), .rd_addr_lsb(rd_addr_lsb),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .wr_permit(wr_permit),
    .prot_on(prot_on), .id_mode(id_mode)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ld(input logic [14:0] a, input logic [15:0] d, input logic wp);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d; wp_end = wp;
    @(negedge clk);
    ld_valid = 1'b0; wp_end = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk);
    wp_end = 1'b1;
    @(negedge clk);
    wp_end = 1'b0;
  endtask

  task automatic key_head();
    ld(15'h5555, 16'hAAAA, 1'b0);
    ld(15'h2AAA, 16'h5555, 1'b0);
  endtask

  task automatic key_arm();
    key_head();
    ld(15'h5555, 16'hA0A0, 1'b0);
  endtask

  task automatic key_disarm();
    key_head();
    ld(15'h5555, 16'h8080, 1'b0);
    key_head();
    ld(15'h5555, 16'h2020, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 prot_on", 16'(prot_on), 16'd0);
    check("R1 id_mode", 16'(id_mode), 16'd0);
    check("R1 wr_permit", 16'(wr_permit), 16'd1);
    check("R6 rd_data passthrough", rd_data, 16'h1234);
  endtask

  task automatic t_arm();
    key_arm();
    check("R4 permit after arm", 16'(wr_permit), 16'd1);
    check("R2 prot not yet set", 16'(prot_on), 16'd0);
    pulse_end();
    check("R4 prot set at end", 16'(prot_on), 16'd1);
    check("R4 permit drops", 16'(wr_permit), 16'd0);
  endtask

  task automatic t_unkeyed();
    ld(15'h0100, 16'h5A5A, 1'b0);
    check("R3 unkeyed load no permit", 16'(wr_permit), 16'd0);
    pulse_end();
    check("R3 prot kept", 16'(prot_on), 16'd1);
    check("R3 still locked", 16'(wr_permit), 16'd0);
  endtask

  task automatic t_rekey();
    key_arm();
    check("R3 rekey permits", 16'(wr_permit), 16'd1);
    ld(15'h0203, 16'h1111, 1'b0);
    check("R3 permit across data load", 16'(wr_permit), 16'd1);
    pulse_end();
    check("R3 relocked after end", 16'(wr_permit), 16'd0);
    check("R2 prot stays", 16'(prot_on), 16'd1);
  endtask

  task automatic t_mismatch();
    ld(15'h5555, 16'hAAAA, 1'b0);
    ld(15'h2AAA, 16'h1234, 1'b0);
    ld(15'h2AAA, 16'h5555, 1'b0);
    ld(15'h5555, 16'hA0A0, 1'b0);
    check("R8 broken key rejected", 16'(wr_permit), 16'd0);
    ld(15'h5555, 16'hAAAA, 1'b0);
    key_head();
    ld(15'h5555, 16'hA0A0, 1'b0);
    check("R8 restart on stray first word", 16'(wr_permit), 16'd1);
    pulse_end();
    check("R8 relocked", 16'(wr_permit), 16'd0);
  endtask

  task automatic t_collide();
    key_disarm();
    check("R5 disarm permits", 16'(wr_permit), 16'd1);
    key_head();
    ld(15'h5555, 16'hA0A0, 1'b1);
    check("R9 old disarm applied", 16'(prot_on), 16'd0);
    check("R9 new permit kept", 16'(wr_permit), 16'd1);
    pulse_end();
    check("R9 new arm applied", 16'(prot_on), 16'd1);
  endtask

  task automatic t_disarm();
    key_disarm();
    check("R5 permit", 16'(wr_permit), 16'd1);
    check("R5 prot before end", 16'(prot_on), 16'd1);
    pulse_end();
    check("R5 prot cleared", 16'(prot_on), 16'd0);
    check("R5 permit open", 16'(wr_permit), 16'd1);
  endtask

  task automatic t_ident();
    key_head();
    ld(15'h5555, 16'h9090, 1'b0);
    check("R6 id entered", 16'(id_mode), 16'd1);
    rd_addr_lsb = 1'b0;
    #1 check("R6 mfr code", rd_data, 16'h001F);
    rd_addr_lsb = 1'b1;
    #1 check("R6 dev code", rd_data, 16'h0025);
    key_head();
    ld(15'h5555, 16'hF0F0, 1'b0);
    check("R7 id left", 16'(id_mode), 16'd0);
    check("R7 array data back", rd_data, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_unkeyed();
    t_rekey();
    t_mismatch();
    t_collide();
    t_disarm();
    t_ident();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule